// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

An 8-bit (width-parameterised) timer that counts in a triangle. It counts up one step per enabled tick from zero to a turnaround value. It holds that value for one tick, then counts back down to zero, and the cycle repeats. The turnaround value is selected by one input: either the largest count (all ones) or the active compare value of channel A. Because the waveform is symmetric about the turnaround, the pulse centres stay fixed as the duty cycle changes. This makes the block suitable for motor drive and other control loops.

Each of the two compare channels, A and B, drives one registered waveform output. A two-bit output-mode field per channel selects the output behaviour:

- off;
- toggle, which exists only on channel A and only when channel A sets the turnaround;
- a PWM that clears on an upward match and sets on a downward match;
- the same PWM with the polarity reversed.

Compare values pass through a shadow stage and are loaded only at the turnaround, so the duty cycle never changes in the middle of a period. A sticky overflow flag marks every return to zero and is cleared by a write-one input. A tick-enable input takes the place of a clock prescaler.

Top module: `pcpwm_timer`

## Requirements
- R1: On each cycle with `tick_en` high the count moves by one step. It rises from 0 to TOP, stays at TOP for exactly one tick, then falls back to 0 and rises again. `down` is 1 while the count is falling.
- R2: With `top_sel` = 0, TOP is all ones (255). With `top_sel` = 1, TOP is the active (loaded) compare value of channel A.
- R3: Output-mode code 2 (non-inverted) drives the output to 0 on a match during an upward step and to 1 on a match during a downward step. With compare value v (0 < v < TOP), the output is high for 2·v of the 2·TOP ticks in a period.
- R4: Output-mode code 3 (inverted) reverses R3. The output goes to 1 on an upward match and to 0 on a downward match, so it is high for 2·TOP − 2·v ticks.
- R5: Output-mode code 1 on channel A, with `top_sel` = 1, inverts `wave_a` on every compare match, which gives one edge per period. Code 1 on channel B, or on channel A with `top_sel` = 0, holds the output at 0.
- R6: Output-mode code 0 holds the channel output at 0.
- R7: Values on `cmp_a` and `cmp_b` take effect only on the tick taken while the count is at TOP. A change made in the middle of a period does not move the edges of that period.
- R8: A compare value equal to TOP gives a constant output: high in code 2, low in code 3. A compare value of 0 gives a constant output: low in code 2, high in code 3. There is no pulse at either turnaround.
- R9: `ovf_flag` becomes 1 on the tick in which the count reaches 0 and stays 1 until `ovf_clr` is pulsed. A new overflow on the same tick as the clear wins.
- R10: While `tick_en` is low, the count, the direction and the outputs hold their values.
- R11: With TOP = 255 and `tick_en` held high, the count returns to 0 every 510 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick qualifier (prescaler output) |
| top_sel | input | 1 | 0: TOP is all ones; 1: TOP is the active channel-A compare value |
| cmp_a | input | 8 | Channel A compare value (shadowed) |
| cmp_b | input | 8 | Channel B compare value (shadowed) |
| omode_a | input | 2 | Channel A output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| omode_b | input | 2 | Channel B output mode: 0 off, 1 off, 2 non-inverted, 3 inverted |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky overflow flag |
| count_o | output | 8 | Current count |
| down | output | 1 | Count direction, 1 while falling |

## Verification
The step and hold properties assume that `tick_en` is low during reset. The bench keeps it low until reset is released and only then enables ticks. The one-step-per-tick property assumes that TOP is not zero: a channel-A compare of zero in `top_sel` = 1 freezes the count, so the vector table never loads a zero turnaround. The bench changes the mode fields only between measurement windows. It waits more than two full periods after each change, so that shadow loading and the first turnaround complete before any waveform is counted.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } omode_e;

endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic         dn_o,
    output logic         step_dn_o,
    output logic         at_top_o,
    output logic         bottom_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dn;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step_dn;
    logic    top_zero;

    always_comb begin
        top_zero = (top_i == '0);
        if (top_zero)
            step_dn = st_q.dn;
        else if (st_q.cnt >= top_i)
            step_dn = 1'b1;
        else if (st_q.cnt == '0)
            step_dn = 1'b0;
        else
            step_dn = st_q.dn;

        st_d = st_q;
        if (tick_i) begin
            st_d.dn = step_dn;
            if (top_zero)
                st_d.cnt = '0;
            else if (step_dn)
                st_d.cnt = st_q.cnt - 1'b1;
            else
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign dn_o      = st_q.dn;
    assign step_dn_o = step_dn;
    assign at_top_o  = tick_i && (st_q.cnt >= top_i);
    assign bottom_o  = tick_i && (st_d.cnt == '0) && (st_q.cnt != '0);

    // R1: one step per tick when TOP is non-zero
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && top_i != '0 && st_q.cnt <= top_i) |=>
        (st_q.cnt == $past(st_q.cnt) + 1'b1 || st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R1: reaching TOP while rising turns the count around
    a_r1_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && top_i != '0 && st_q.cnt == top_i && !st_q.dn) |=> st_q.dn);

    // R10: no tick, no movement
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(st_q.cnt) && $stable(st_q.dn)));

endmodule

// File: rtl/pcpwm_cmp_buf.sv
module pcpwm_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] nxt_a_i,
    input  logic [W-1:0] nxt_b_i,
    output logic [W-1:0] act_a_o,
    output logic [W-1:0] act_b_o
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.a = nxt_a_i;
            st_d.b = nxt_b_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_a_o = st_q.a;
    assign act_b_o = st_q.b;

    // R7: active compares move only on a turnaround load
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(st_q.a) && $stable(st_q.b)));

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
    import pcpwm_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_TOGGLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         step_dn_i,
    input  logic [1:0]   omode_i,
    input  logic         tog_ok_i,
    output logic         wave_o
);

    typedef struct packed {
        logic wave;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   match;
    logic   tog_en;

    generate
        if (HAS_TOGGLE) begin : g_tog
            assign tog_en = tog_ok_i;
        end else begin : g_notog
            assign tog_en = 1'b0;
        end
    endgenerate

    always_comb begin
        match = tick_i && (cnt_i == cmp_i);
        st_d  = st_q;
        case (omode_e'(omode_i))
            OM_NONINV: if (match) st_d.wave = step_dn_i;
            OM_INV:    if (match) st_d.wave = !step_dn_i;
            OM_TOGGLE: begin
                if (!tog_en)    st_d.wave = 1'b0;
                else if (match) st_d.wave = !st_q.wave;
            end
            default:   st_d.wave = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave_o = st_q.wave;

    // R6: disconnected channel drives low
    a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_i == OM_OFF) |=> !wave_o);

    // R3: non-inverted clears on a rising-step match
    a_r3_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_i == OM_NONINV && tick_i && cnt_i == cmp_i && !step_dn_i) |=> !wave_o);

    // R4: inverted sets on a rising-step match
    a_r4_up_set: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_i == OM_INV && tick_i && cnt_i == cmp_i && !step_dn_i) |=> wave_o);

    generate
        if (!HAS_TOGGLE) begin : g_chk_notog
            // R5: no toggle on this channel
            a_r5_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
                (omode_i == OM_TOGGLE) |=> !wave_o);
        end
    endgenerate

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         top_sel,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic [1:0]   omode_a,
    input  logic [1:0]   omode_b,
    input  logic         ovf_clr,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovf_flag,
    output logic [W-1:0] count_o,
    output logic         down
);

    localparam logic [W-1:0] TOP_MAX = '1;

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t      st_d, st_q;
    logic [W-1:0] top_val;
    logic [W-1:0] act_a, act_b;
    logic         step_dn, at_top, bottom_evt;

    assign top_val = top_sel ? act_a : TOP_MAX;

    pcpwm_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .top_i     (top_val),
        .cnt_o     (count_o),
        .dn_o      (down),
        .step_dn_o (step_dn),
        .at_top_o  (at_top),
        .bottom_o  (bottom_evt)
    );

    pcpwm_cmp_buf #(.W(W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (at_top),
        .nxt_a_i (cmp_a),
        .nxt_b_i (cmp_b),
        .act_a_o (act_a),
        .act_b_o (act_b)
    );

    pcpwm_channel #(.W(W), .HAS_TOGGLE(1'b1)) u_cha (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .cnt_i     (count_o),
        .cmp_i     (act_a),
        .step_dn_i (step_dn),
        .omode_i   (omode_a),
        .tog_ok_i  (top_sel),
        .wave_o    (wave_a)
    );

    pcpwm_channel #(.W(W), .HAS_TOGGLE(1'b0)) u_chb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .cnt_i     (count_o),
        .cmp_i     (act_b),
        .step_dn_i (step_dn),
        .omode_i   (omode_b),
        .tog_ok_i  (top_sel),
        .wave_o    (wave_b)
    );

    always_comb begin
        st_d = st_q;
        if (ovf_clr)    st_d.ovf = 1'b0;
        if (bottom_evt) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag = st_q.ovf;

    // R9: flag rises when the count lands on zero
    a_r9_set_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count_o == 1 && down && top_val > 1) |=> ovf_flag);

    // R9: flag is sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R5: channel A toggle disabled when TOP is fixed
    a_r5_fixed_top_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_a == OM_TOGGLE && !top_sel) |=> !wave_a);

endmodule

// File: tb/sim_pcpwm_timer.sv
module sim_pcpwm_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       top_sel = 1'b0;
    logic [7:0] cmp_a = '0;
    logic [7:0] cmp_b = '0;
    logic [1:0] omode_a = '0;
    logic [1:0] omode_b = '0;
    logic       ovf_clr = 1'b0;
    logic       wave_a, wave_b, ovf_flag, down;
    logic [7:0] count_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pcpwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .top_sel(top_sel),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .omode_a(omode_a), .omode_b(omode_b),
        .ovf_clr(ovf_clr), .wave_a(wave_a), .wave_b(wave_b),
        .ovf_flag(ovf_flag), .count_o(count_o), .down(down)
    );

    typedef struct packed {
        logic       sel;
        logic [7:0] a;
        logic [7:0] b;
        logic [1:0] ma;
        logic [1:0] mb;
        logic       chk_hi_a;
        logic [9:0] hi_a;
        logic [9:0] hi_b;
        logic [9:0] edges_a;
    } vec_t;

    // {sel, cmp_a, cmp_b, mode_a, mode_b, check_hi_a, hi_a, hi_b, edges_a}
    localparam vec_t VECS [7] = '{
        '{1'b0, 8'd100, 8'd40,  2'd2, 2'd3, 1'b1, 10'd200, 10'd430, 10'd2},
        '{1'b0, 8'd0,   8'd255, 2'd2, 2'd2, 1'b1, 10'd0,   10'd510, 10'd0},
        '{1'b0, 8'd255, 8'd0,   2'd3, 2'd3, 1'b1, 10'd0,   10'd510, 10'd0},
        '{1'b1, 8'd50,  8'd20,  2'd2, 2'd2, 1'b1, 10'd100, 10'd40,  10'd0},
        '{1'b1, 8'd60,  8'd60,  2'd1, 2'd1, 1'b0, 10'd0,   10'd0,   10'd1},
        '{1'b0, 8'd77,  8'd200, 2'd1, 2'd0, 1'b1, 10'd0,   10'd0,   10'd0},
        '{1'b1, 8'd30,  8'd10,  2'd3, 2'd3, 1'b1, 10'd0,   10'd40,  10'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int errs;
        int held;
        int n;
        repeat (5) @(negedge clk);
        // reset state
        chk("R1 reset count", count_o, 0);
        chk("R6 reset wave_a", wave_a, 0);
        chk("R9 reset ovf", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        tick_en = 1'b1;

        // R1 / R2: rising slope to fixed TOP
        errs = 0;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            if (count_o != k[7:0]) errs++;
        end
        chk("R1 R2 up slope to 255", errs, 0);
        @(negedge clk);
        chk("R1 one tick at TOP then down", count_o, 254);
        chk("R1 down flag", down, 1);

        // R10: no tick, no movement
        tick_en = 1'b0;
        held = count_o;
        repeat (20) @(negedge clk);
        chk("R10 count holds", count_o, held);
        tick_en = 1'b1;

        // R9 / R11
        while (count_o != 0) @(negedge clk);
        chk("R9 ovf at bottom", ovf_flag, 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (count_o != 0);
        chk("R11 period 510", n, 510);
        repeat (20) @(negedge clk);
        chk("R9 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 ovf cleared", ovf_flag, 0);

        // vector table: R2 R3 R4 R5 R6 R8
        foreach (VECS[i]) begin
            int t, hi_a, hi_b, edg, zeros, mx;
            logic prev;
            top_sel = VECS[i].sel;
            cmp_a   = VECS[i].a;
            cmp_b   = VECS[i].b;
            omode_a = VECS[i].ma;
            omode_b = VECS[i].mb;
            repeat (1100) @(negedge clk);
            t = VECS[i].sel ? int'(VECS[i].a) : 255;
            hi_a = 0; hi_b = 0; edg = 0; zeros = 0; mx = 0;
            prev = wave_a;
            for (int c = 0; c < 2 * t; c++) begin
                @(negedge clk);
                if (wave_a) hi_a++;
                if (wave_b) hi_b++;
                if (wave_a != prev) edg++;
                prev = wave_a;
                if (count_o == 0) zeros++;
                if (int'(count_o) > mx) mx = int'(count_o);
            end
            chk($sformatf("R2 vec%0d max count", i), mx, t);
            chk($sformatf("R1 vec%0d bottoms per period", i), zeros, 1);
            if (VECS[i].chk_hi_a)
                chk($sformatf("R3 R4 R8 vec%0d wave_a high", i), hi_a, int'(VECS[i].hi_a));
            chk($sformatf("R4 R5 R6 vec%0d wave_b high", i), hi_b, int'(VECS[i].hi_b));
            chk($sformatf("R5 vec%0d wave_a edges", i), edg, int'(VECS[i].edges_a));
        end

        // R7: mid-period change waits for TOP
        top_sel = 1'b0; cmp_a = 8'd100; cmp_b = 8'd40; omode_a = 2'd2; omode_b = 2'd0;
        repeat (1100) @(negedge clk);
        while (!(count_o == 50 && !down)) @(negedge clk);
        chk("R3 high below compare", wave_a, 1);
        cmp_a = 8'd200;
        while (!(count_o == 150 && !down)) @(negedge clk);
        chk("R7 old compare still active", wave_a, 0);
        while (!(count_o == 100 && down)) @(negedge clk);
        while (!(count_o == 150 && !down)) @(negedge clk);
        chk("R7 new compare after TOP", wave_a, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule